// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block watches a running calendar clock and raises an alarm once the clock reaches a programmed minute and hour on any weekday chosen by a seven-bit day mask. Because the day is a mask and not a date, the alarm can only be set up to one week ahead. Matching works to the minute. A separate interrupt, which fires once per second, lets software wait for an exact second after the minute alarm has fired.

Timekeeping lies outside the block. The clock supplies seconds, minutes and hours as BCD bytes, the weekday as a binary index from 0 to 6, and a single-cycle pulse when the time advances. During the pulse cycle the time inputs already show the new time. Software reaches the block through a simple write port and a registered read port. Both status flags are sticky and are cleared by writing 1 to them. One interrupt line carries the OR of the flags whose enables are set.

Top module: `weekly_alarm_cmp`

## Requirements
- R1: After synchronous reset, every register reads 0, both flags are 0 and `irq` is 0.
- R2: The write port stores the minute (address 0, BCD) and the hour (address 1, BCD). It stores the weekday mask at address 2, where bit k selects weekday k for k from 0 to 6 and bit 7 reads back as 0. The control register is at address 3 and keeps only bit 4 (alarm enable) and bit 3 (second enable); its other bits read as 0.
- R3: The alarm flag (status address 4, bit 0) sets on a tick when all of these hold at that tick: the seconds equal 0x00, the minute and hour equal the programmed values, the mask bit of the current weekday is 1, and the alarm enable is 1.
- R4: The alarm never sets on a tick with nonzero seconds, on a cycle with no tick, or when the minute or hour differs. A matching minute therefore gives only one alarm event.
- R5: The alarm does not fire on a weekday whose mask bit is 0. When several mask bits are set, it fires on each of those days.
- R6: The second flag (status bit 1) sets on every tick while the second enable is 1, and never while that enable is 0.
- R7: The flags are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` equals (alarm flag AND alarm enable) OR (second flag AND second enable). It changes on the same edge as the flags and the enables. Clearing an enable masks `irq` but leaves the flag set.
- R9: Writing 0 to the control register turns off both interrupts. After that write, no tick sets either flag and `irq` stays 0.
- R10: `rd_data` shows the addressed register one cycle after `rd_en` and holds that value until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | Single-cycle pulse on each advance of the time |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 3 | Current weekday index, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| alarm_flag | output | 1 | Sticky alarm status |
| sec_flag | output | 1 | Sticky once-per-second status |
| irq | output | 1 | OR of the enabled flags |

## Verification
The bench targets the ticks that fall inside a matching minute but not at second zero. A comparator that looked at the whole minute would raise up to sixty events there, not one. It also drives a cycle that shows a matching time with no tick. The weekday cases use both a single mask bit and two mask bits, so a design that decodes the index wrongly, or honours only one bit, fires on the wrong day. For the status register, the bench clears a flag in the same cycle that a tick sets it, and writes 0 to it. A design where the clear wins, or where any write clears, drops the flag. Finally, the bench turns off an enable while its flag is set, to catch a design that clears the flag instead of masking `irq`.

// File: rtl/wam_pkg.sv
package wam_pkg;
  localparam int unsigned ADR_ALM_MIN  = 0;
  localparam int unsigned ADR_ALM_HOUR = 1;
  localparam int unsigned ADR_ALM_DAYS = 2;
  localparam int unsigned ADR_CTRL     = 3;
  localparam int unsigned ADR_STATUS   = 4;

  localparam int unsigned CTRL_SEC_EN_BIT = 3;
  localparam int unsigned CTRL_ALM_EN_BIT = 4;
  localparam int unsigned STAT_ALM_BIT    = 0;
  localparam int unsigned STAT_SEC_BIT    = 1;
endpackage

// File: rtl/wam_regs.sv
module wam_regs
  import wam_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int BCD_W  = 8,
  parameter int DAYS   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              flag_alarm,
  input  logic              flag_sec,
  output logic [DATA_W-1:0] rd_data,
  output logic [BCD_W-1:0]  alm_min,
  output logic [BCD_W-1:0]  alm_hour,
  output logic [DAYS-1:0]   alm_mask,
  output logic              en_alarm_q,
  output logic              en_sec_q,
  output logic              en_alarm_d,
  output logic              en_sec_d,
  output logic              clr_alarm,
  output logic              clr_sec
);
  logic wr_min, wr_hour, wr_days, wr_ctrl, wr_stat;
  logic [DATA_W-1:0] rd_mux;

  assign wr_min  = wr_en && (wr_addr == ADDR_W'(ADR_ALM_MIN));
  assign wr_hour = wr_en && (wr_addr == ADDR_W'(ADR_ALM_HOUR));
  assign wr_days = wr_en && (wr_addr == ADDR_W'(ADR_ALM_DAYS));
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign wr_stat = wr_en && (wr_addr == ADDR_W'(ADR_STATUS));

  assign en_alarm_d = wr_ctrl ? wr_data[CTRL_ALM_EN_BIT] : en_alarm_q;
  assign en_sec_d   = wr_ctrl ? wr_data[CTRL_SEC_EN_BIT] : en_sec_q;
  assign clr_alarm  = wr_stat && wr_data[STAT_ALM_BIT];
  assign clr_sec    = wr_stat && wr_data[STAT_SEC_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_min    <= '0;
      alm_hour   <= '0;
      alm_mask   <= '0;
      en_alarm_q <= 1'b0;
      en_sec_q   <= 1'b0;
    end else begin
      if (wr_min)  alm_min  <= wr_data[BCD_W-1:0];
      if (wr_hour) alm_hour <= wr_data[BCD_W-1:0];
      if (wr_days) alm_mask <= wr_data[DAYS-1:0];
      en_alarm_q <= en_alarm_d;
      en_sec_q   <= en_sec_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_W'(ADR_ALM_MIN):  rd_mux = DATA_W'(alm_min);
      ADDR_W'(ADR_ALM_HOUR): rd_mux = DATA_W'(alm_hour);
      ADDR_W'(ADR_ALM_DAYS): rd_mux = DATA_W'(alm_mask);
      ADDR_W'(ADR_CTRL): begin
        rd_mux[CTRL_ALM_EN_BIT] = en_alarm_q;
        rd_mux[CTRL_SEC_EN_BIT] = en_sec_q;
      end
      ADDR_W'(ADR_STATUS): begin
        rd_mux[STAT_ALM_BIT] = flag_alarm;
        rd_mux[STAT_SEC_BIT] = flag_sec;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/wam_match.sv
module wam_match #(
  parameter int BCD_W  = 8,
  parameter int DAYS   = 7,
  parameter int WDAY_W = 3
) (
  input  logic              tick_1s,
  input  logic [BCD_W-1:0]  cur_sec,
  input  logic [BCD_W-1:0]  cur_min,
  input  logic [BCD_W-1:0]  cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [BCD_W-1:0]  alm_min,
  input  logic [BCD_W-1:0]  alm_hour,
  input  logic [DAYS-1:0]   alm_mask,
  input  logic              en_alarm,
  output logic              alarm_hit
);
  logic [DAYS-1:0] day_hit;
  logic            top_of_minute;
  logic            time_eq;

  for (genvar k = 0; k < DAYS; k++) begin : g_day
    assign day_hit[k] = alm_mask[k] && (cur_wday == WDAY_W'(k));
  end

  assign top_of_minute = tick_1s && (cur_sec == '0);
  assign time_eq       = (cur_min == alm_min) && (cur_hour == alm_hour);
  assign alarm_hit     = en_alarm && top_of_minute && time_eq && (|day_hit);
endmodule

// File: rtl/wam_status.sv
module wam_status (
  input  logic clk,
  input  logic rst,
  input  logic set_alarm,
  input  logic set_sec,
  input  logic clr_alarm,
  input  logic clr_sec,
  input  logic en_alarm_d,
  input  logic en_sec_d,
  output logic alarm_flag,
  output logic sec_flag,
  output logic irq
);
  logic alarm_d, sec_d;

  assign alarm_d = set_alarm || (alarm_flag && !clr_alarm);
  assign sec_d   = set_sec   || (sec_flag   && !clr_sec);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_flag <= 1'b0;
      sec_flag   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      alarm_flag <= alarm_d;
      sec_flag   <= sec_d;
      irq        <= (alarm_d && en_alarm_d) || (sec_d && en_sec_d);
    end
  end
endmodule

// File: rtl/weekly_alarm_cmp.sv
module weekly_alarm_cmp #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int BCD_W  = 8,
  parameter int DAYS   = 7,
  localparam int WDAY_W = $clog2(DAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s,
  input  logic [BCD_W-1:0]  cur_sec,
  input  logic [BCD_W-1:0]  cur_min,
  input  logic [BCD_W-1:0]  cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_flag,
  output logic              sec_flag,
  output logic              irq
);
  logic [BCD_W-1:0] alm_min, alm_hour;
  logic [DAYS-1:0]  alm_mask;
  logic en_alarm_q, en_sec_q, en_alarm_d, en_sec_d;
  logic clr_alarm, clr_sec, alarm_hit, sec_hit;

  wam_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BCD_W(BCD_W), .DAYS(DAYS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .flag_alarm(alarm_flag), .flag_sec(sec_flag),
    .rd_data(rd_data), .alm_min(alm_min), .alm_hour(alm_hour), .alm_mask(alm_mask),
    .en_alarm_q(en_alarm_q), .en_sec_q(en_sec_q), .en_alarm_d(en_alarm_d),
    .en_sec_d(en_sec_d), .clr_alarm(clr_alarm), .clr_sec(clr_sec)
  );

  wam_match #(.BCD_W(BCD_W), .DAYS(DAYS), .WDAY_W(WDAY_W)) match_i (
    .tick_1s(tick_1s), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .alm_min(alm_min), .alm_hour(alm_hour), .alm_mask(alm_mask),
    .en_alarm(en_alarm_q), .alarm_hit(alarm_hit)
  );

  assign sec_hit = tick_1s && en_sec_q;

  wam_status status_i (
    .clk(clk), .rst(rst), .set_alarm(alarm_hit), .set_sec(sec_hit),
    .clr_alarm(clr_alarm), .clr_sec(clr_sec), .en_alarm_d(en_alarm_d),
    .en_sec_d(en_sec_d), .alarm_flag(alarm_flag), .sec_flag(sec_flag), .irq(irq)
  );
endmodule

// File: rtl/wam_checker.sv
module wam_checker #(
  parameter int BCD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_1s,
  input logic [BCD_W-1:0] cur_sec,
  input logic             en_alarm,
  input logic             en_sec,
  input logic             alarm_flag,
  input logic             sec_flag,
  input logic             irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq && !alarm_flag && !sec_flag));

  assert_alarm_at_minute_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> ($past(tick_1s) && ($past(cur_sec) == '0) && $past(en_alarm)));

  assert_no_midminute_alarm_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_1s && (cur_sec != '0) && !alarm_flag) |=> !alarm_flag);

  assert_sec_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_flag) |-> ($past(tick_1s) && $past(en_sec)));

  assert_irq_masking_R8: assert property (@(posedge clk) disable iff (rst)
    irq == ((alarm_flag && en_alarm) || (sec_flag && en_sec)));

  assert_disabled_stays_low_R9: assert property (@(posedge clk) disable iff (rst)
    (!en_alarm && !alarm_flag) |=> !alarm_flag);
endmodule

bind weekly_alarm_cmp wam_checker #(.BCD_W(BCD_W)) chk_i (
  .clk(clk), .rst(rst), .tick_1s(tick_1s), .cur_sec(cur_sec),
  .en_alarm(en_alarm_q), .en_sec(en_sec_q), .alarm_flag(alarm_flag),
  .sec_flag(sec_flag), .irq(irq)
);

// File: tb/weekly_alarm_cmp_tb_top.sv
module weekly_alarm_cmp_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       tick_1s = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm_flag, sec_flag, irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  weekly_alarm_cmp dut_i (
    .clk(clk), .rst(rst), .tick_1s(tick_1s), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_flag(alarm_flag), .sec_flag(sec_flag), .irq(irq)
  );

  // behavioural reference, updated at every rising edge
  logic [7:0] m_min, m_hour, m_rd;
  logic [6:0] m_mask;
  bit m_aen, m_sen, m_fa, m_fs, m_irq, m_rd_v;

  always @(posedge clk) begin
    bit sa, ss;
    logic [7:0] rv;
    if (rst) begin
      m_min = 0; m_hour = 0; m_mask = 0; m_aen = 0; m_sen = 0;
      m_fa = 0; m_fs = 0; m_irq = 0; m_rd = 0; m_rd_v = 0;
    end else begin
      case (rd_addr)
        3'd0: rv = m_min;
        3'd1: rv = m_hour;
        3'd2: rv = {1'b0, m_mask};
        3'd3: rv = {3'b000, m_aen, m_sen, 3'b000};
        3'd4: rv = {6'b0, m_fs, m_fa};
        default: rv = 8'h00;
      endcase
      if (rd_en) m_rd = rv;
      m_rd_v = rd_en;
      sa = tick_1s && cur_sec == 8'h00 && cur_min == m_min && cur_hour == m_hour &&
           cur_wday < 3'd7 && m_mask[cur_wday] && m_aen;
      ss = tick_1s && m_sen;
      if (wr_en && wr_addr == 3'd4) begin
        if (wr_data[0]) m_fa = 0;
        if (wr_data[1]) m_fs = 0;
      end
      if (sa) m_fa = 1;
      if (ss) m_fs = 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_min = wr_data;
          3'd1: m_hour = wr_data;
          3'd2: m_mask = wr_data[6:0];
          3'd3: begin m_aen = wr_data[4]; m_sen = wr_data[3]; end
          default: ;
        endcase
      end
      m_irq = (m_fa && m_aen) || (m_fs && m_sen);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(alarm_flag == m_fa, "R3 alarm_flag vs model", alarm_flag, m_fa);
    check(sec_flag == m_fs, "R6 sec_flag vs model", sec_flag, m_fs);
    check(irq == m_irq, "R8 irq vs model", irq, m_irq);
    if (m_rd_v) check(rd_data == m_rd, "R10 rd_data vs model", rd_data, m_rd);
    wr_en = 0; rd_en = 0; tick_1s = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_en = 1; rd_addr = a; step(); v = rd_data;
  endtask

  task automatic tk(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s, input logic [2:0] w);
    tick_1s = 1; cur_hour = h; cur_min = m; cur_sec = s; cur_wday = w; step();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check(!alarm_flag && !sec_flag && !irq, "R1 flags after reset", {alarm_flag, sec_flag, irq}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 register after reset", v, 0);
    end
    // R2: programming and readback
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'h84); wr(3'd3, 8'hFF);
    rd(3'd2, v); check(v == 8'h04, "R2 mask bit7 dropped", v, 8'h04);
    rd(3'd3, v); check(v == 8'h18, "R2 control keeps bits 4,3", v, 8'h18);
    rd(3'd0, v); check(v == 8'h34, "R2 minute readback", v, 8'h34);
    rd(3'd1, v); check(v == 8'h12, "R2 hour readback", v, 8'h12);
    wr(3'd3, 8'h10);
    // R3: match at top of minute
    tk(8'h12, 8'h33, 8'h59, 3'd2);
    check(!alarm_flag, "R3 no alarm before minute", alarm_flag, 0);
    tk(8'h12, 8'h34, 8'h00, 3'd2);
    check(alarm_flag && irq, "R3 alarm at 12:34:00", {alarm_flag, irq}, 3);
    rd(3'd4, v); check(v == 8'h01, "R3 status bit0", v, 1);
    // R4: no further events inside the minute
    wr(3'd4, 8'h01);
    check(!alarm_flag && !irq, "R7 clear alarm", {alarm_flag, irq}, 0);
    tk(8'h12, 8'h34, 8'h01, 3'd2);
    tk(8'h12, 8'h34, 8'h02, 3'd2);
    check(!alarm_flag, "R4 nonzero seconds", alarm_flag, 0);
    tk(8'h12, 8'h35, 8'h00, 3'd2);
    check(!alarm_flag, "R4 minute differs", alarm_flag, 0);
    cur_min = 8'h34; cur_sec = 8'h00; step();
    check(!alarm_flag, "R4 no tick no alarm", alarm_flag, 0);
    // R5: weekday mask
    tk(8'h12, 8'h34, 8'h00, 3'd3);
    check(!alarm_flag, "R5 day bit clear", alarm_flag, 0);
    wr(3'd2, 8'h0A);
    tk(8'h12, 8'h34, 8'h00, 3'd3);
    check(alarm_flag, "R5 day3 of two", alarm_flag, 1);
    wr(3'd4, 8'h01);
    tk(8'h12, 8'h34, 8'h00, 3'd1);
    check(alarm_flag, "R5 day1 of two", alarm_flag, 1);
    wr(3'd4, 8'h01);
    tk(8'h12, 8'h34, 8'h00, 3'd2);
    check(!alarm_flag, "R5 day2 now cleared", alarm_flag, 0);
    // R6 / R7: second interrupt
    wr(3'd3, 8'h08);
    tk(8'h01, 8'h02, 8'h03, 3'd0);
    check(sec_flag && irq, "R6 second flag sets", {sec_flag, irq}, 3);
    wr(3'd4, 8'h00);
    check(sec_flag, "R7 write 0 keeps flag", sec_flag, 1);
    tick_1s = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 8'h02; step();
    check(sec_flag, "R7 set wins over clear", sec_flag, 1);
    wr(3'd4, 8'h02);
    check(!sec_flag, "R7 write 1 clears", sec_flag, 0);
    tk(8'h01, 8'h02, 8'h04, 3'd0);
    check(sec_flag, "R6 sets again next tick", sec_flag, 1);
    // R8: masking
    wr(3'd3, 8'h18);
    tk(8'h12, 8'h34, 8'h00, 3'd1);
    check(alarm_flag && sec_flag && irq, "R8 both flags", {alarm_flag, sec_flag, irq}, 7);
    wr(3'd3, 8'h00);
    check(!irq && alarm_flag && sec_flag, "R8 masked, flags kept", {alarm_flag, sec_flag, irq}, 6);
    wr(3'd3, 8'h08);
    check(irq, "R8 second enable alone", irq, 1);
    // R9: control zero
    wr(3'd3, 8'h00); wr(3'd4, 8'h03);
    tk(8'h12, 8'h34, 8'h00, 3'd1);
    check(!alarm_flag && !sec_flag && !irq, "R9 both disabled", {alarm_flag, sec_flag, irq}, 0);
    rd(3'd3, v); check(v == 8'h00, "R9 control reads 0", v, 0);
    // R10: read latency and hold
    wr(3'd0, 8'h59);
    rd(3'd0, v); check(v == 8'h59, "R10 read after one cycle", v, 8'h59);
    step(); check(rd_data == 8'h59, "R10 hold without rd_en", rd_data, 8'h59);
    rd(3'd5, v); check(v == 8'h00, "R10 unmapped reads 0", v, 0);
    repeat (4) step();
    done = 1;
    summary();
    $finish;
  end
endmodule